// File: doc/BRIEF.md
# Selectable-Source Shared Time Base

This block is a free-running up-counter that gives a bank of capture/compare channels one shared notion of time. Software picks what advances it: one of two fixed divisions of the system clock, a one-cycle overflow pulse from a neighbouring timer, or rising edges on an external pin. The count only moves while a run bit is set, and it can be frozen while the system is in idle mode.

When the counter rolls over from all ones to zero, a sticky overflow flag is set. An interrupt request follows the flag when the overflow interrupt is enabled. The flag stays set until software writes it back to zero. Software can also write a one to it, to raise a test interrupt. A small byte-wide register port gives access to the control bits, the flag and each byte of the count. Everything runs on a single clock. The clock divisions and the pin edge become one-cycle enables.

Top module: `shared_tbase`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, all control bits are 0 and the interrupt request is low. Register map: address 0 is control (bit 0 run, bits 2:1 source, bit 3 idle-stop, bit 4 overflow interrupt enable), address 1 is status (bit 0 overflow flag), address 2 is the count low byte and address 3 is the count high byte. Every register reads back at its own address.
- R2: With source 2'b00 and run set, the count advances by exactly one for every 12 system clocks.
- R3: With source 2'b01 and run set, the count advances by exactly one for every 4 system clocks.
- R4: With source 2'b10 and run set, the count advances by one in each clock cycle in which the cascade overflow input is high.
- R5: With source 2'b11 and run set, the count advances by one for each rising edge of the external input, a few clocks after the edge. A level held high adds no further counts.
- R6: While the run bit is 0, the count holds its value whatever the selected source does.
- R7: While idle-stop is 1 and the idle input is high, the count holds. With idle-stop 0, the idle input has no effect on counting.
- R8: An increment from 0xFFFF gives 0x0000 and sets the overflow flag. The flag stays set until software writes 0 to status bit 0.
- R9: The interrupt request is high exactly when the overflow flag and the interrupt enable bit are both 1.
- R10: A software write of 1 to status bit 0 sets the overflow flag.
- R11: A write to either count byte replaces that byte, and no increment happens in that cycle.
- R12: A hardware overflow in the same cycle as a software write of 0 to the flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| casc_ovf_i | input | 1 | Overflow pulse from a neighbouring timer |
| ext_cnt_i | input | 1 | Asynchronous external count input |
| idle_i | input | 1 | System idle-mode indication |
| count_o | output | 16 | Current time-base value |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two pairs of events can fall in the same cycle. A software write to a count byte can meet an increment, and a hardware roll-over can meet a software write that clears the flag. The bench provokes both with the cascade source, because that source lets it place an increment in a chosen cycle. It raises the overflow pulse on the same falling edge at which it presents the register write. After the next rising edge it compares the written byte, the untouched byte and the flag against the precedence in R11 and R12.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

   typedef enum logic [1:0] {
      SRC_DIV_A   = 2'b00,
      SRC_DIV_B   = 2'b01,
      SRC_CASCADE = 2'b10,
      SRC_PIN     = 2'b11
   } src_sel_e;

   localparam int unsigned REG_W        = 8;
   localparam int unsigned CTL_RUN_BIT  = 0;
   localparam int unsigned CTL_SRC_LSB  = 1;
   localparam int unsigned CTL_IDLE_BIT = 3;
   localparam int unsigned CTL_IEN_BIT  = 4;
   localparam int unsigned STS_OVF_BIT  = 0;
   localparam int unsigned ADDR_CTL     = 0;
   localparam int unsigned ADDR_STS     = 1;
   localparam int unsigned ADDR_CNT0    = 2;

endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
   parameter int unsigned DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   if (DIV < 1) begin : g_bad_div
      $error("tbase_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick_o = 1'b1;
   end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] ph_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             ph_q <= '0;
         else if (ph_q == LAST)  ph_q <= '0;
         else                    ph_q <= ph_q + CW'(1);
      end

      assign tick_o = (ph_q == LAST);

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);
   end

endmodule

// File: rtl/tbase_edge.sv
module tbase_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tbase_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;

   // R5
   single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/tbase_count.sv
module tbase_count #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned BYTES = WIDTH / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic [BYTES-1:0] wr_be_i,
   input  logic [7:0]       wr_data_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             wrap_o
);

   if (WIDTH % 8 != 0 || BYTES * 8 != WIDTH) begin : g_bad_width
      $error("tbase_count: WIDTH must be a whole number of bytes");
   end

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;
   logic             any_wr;
   logic             step;

   assign any_wr = |wr_be_i;
   assign step   = inc_i & ~any_wr;

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      always_comb begin
         if (wr_be_i[b]) cnt_d[b*8 +: 8] = wr_data_i;
         else            cnt_d[b*8 +: 8] = cnt_q[b*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + WIDTH'(1);
      else           cnt_q <= cnt_d;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = step & (&cnt_q);

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !any_wr) |=> $stable(cnt_q));

   // R11
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && wr_be_i[0]) |=> (cnt_q[7:0] == $past(wr_data_i)));

   // R8
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/shared_tbase.sv
module shared_tbase
   import tbase_pkg::*;
#(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned DIV_A       = 12,
   parameter int unsigned DIV_B       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = $clog2(ADDR_CNT0 + WIDTH / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              casc_ovf_i,
   input  logic              ext_cnt_i,
   input  logic              idle_i,
   output logic [WIDTH-1:0]  count_o,
   output logic              irq_o
);

   localparam int unsigned BYTES = WIDTH / 8;

   if (WIDTH < 8 || WIDTH % 8 != 0) begin : g_bad_width
      $error("shared_tbase: WIDTH must be a non-zero multiple of 8");
   end
   if ((1 << ADDR_W) < ADDR_CNT0 + BYTES) begin : g_bad_addr
      $error("shared_tbase: ADDR_W too small for register map");
   end

   logic       run_q, idle_stop_q, ien_q, flag_q;
   src_sel_e   src_q;
   logic       tick_a, tick_b, pin_rise, src_tick, inc, wrap;
   logic [BYTES-1:0] wr_be;
   logic       wr_ctl, wr_sts;

   tbase_prescale #(.DIV(DIV_A)) u_pre_a (.clk(clk), .rst_n(rst_n), .tick_o(tick_a));
   tbase_prescale #(.DIV(DIV_B)) u_pre_b (.clk(clk), .rst_n(rst_n), .tick_o(tick_b));

   tbase_edge #(.STAGES(SYNC_STAGES)) u_pin (
      .clk(clk), .rst_n(rst_n), .async_i(ext_cnt_i), .rise_o(pin_rise));

   always_comb begin
      unique case (src_q)
         SRC_DIV_A:   src_tick = tick_a;
         SRC_DIV_B:   src_tick = tick_b;
         SRC_CASCADE: src_tick = casc_ovf_i;
         default:     src_tick = pin_rise;
      endcase
   end

   assign inc = run_q & src_tick & ~(idle_stop_q & idle_i);

   assign wr_ctl = wr_en && (wr_addr == ADDR_W'(ADDR_CTL));
   assign wr_sts = wr_en && (wr_addr == ADDR_W'(ADDR_STS));

   for (genvar b = 0; b < BYTES; b++) begin : g_be
      assign wr_be[b] = wr_en && (wr_addr == ADDR_W'(ADDR_CNT0 + b));
   end

   tbase_count #(.WIDTH(WIDTH), .BYTES(BYTES)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(inc), .wr_be_i(wr_be),
      .wr_data_i(wr_data), .cnt_o(count_o), .wrap_o(wrap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         src_q       <= SRC_DIV_A;
         idle_stop_q <= 1'b0;
         ien_q       <= 1'b0;
      end else if (wr_ctl) begin
         run_q       <= wr_data[CTL_RUN_BIT];
         src_q       <= src_sel_e'(wr_data[CTL_SRC_LSB +: 2]);
         idle_stop_q <= wr_data[CTL_IDLE_BIT];
         ien_q       <= wr_data[CTL_IEN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (wrap)   flag_q <= 1'b1;
      else if (wr_sts) flag_q <= wr_data[STS_OVF_BIT];
   end

   assign irq_o = flag_q & ien_q;

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADDR_CTL)) begin
         rd_data[CTL_RUN_BIT]         = run_q;
         rd_data[CTL_SRC_LSB +: 2]    = src_q;
         rd_data[CTL_IDLE_BIT]        = idle_stop_q;
         rd_data[CTL_IEN_BIT]         = ien_q;
      end else if (rd_addr == ADDR_W'(ADDR_STS)) begin
         rd_data[STS_OVF_BIT]         = flag_q;
      end else begin
         for (int b = 0; b < BYTES; b++) begin
            if (rd_addr == ADDR_W'(ADDR_CNT0 + b)) rd_data = count_o[b*8 +: 8];
         end
      end
   end

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !wr_sts) |=> flag_q);

   // R12
   ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag_q);

   // R6
   stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !(|wr_be)) |=> $stable(count_o));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_stop_q && idle_i && !(|wr_be)) |=> $stable(count_o));

endmodule

// File: tb/shared_tbase_tb.sv
module shared_tbase_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        casc_ovf_i = 1'b0;
   logic        ext_cnt_i = 1'b0;
   logic        idle_i = 1'b0;
   logic [15:0] count_o;
   logic        irq_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   shared_tbase u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .casc_ovf_i(casc_ovf_i), .ext_cnt_i(ext_cnt_i), .idle_i(idle_i),
      .count_o(count_o), .irq_o(irq_o));

   // control encodings: bit0 run, bits2:1 source, bit3 idle-stop, bit4 irq enable
   function automatic logic [7:0] ctl(bit run, logic [1:0] src, bit istop, bit ien);
      return {3'b000, ien, istop, src, run};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic set_count(logic [15:0] v);
      wr(2'd2, v[7:0]);
      wr(2'd3, v[15:8]);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 count", count_o, 0);
      check("R1 irq", irq_o, 0);
      rd(2'd0, d); check("R1 ctrl", d, 0);
      rd(2'd1, d); check("R1 flag", d, 0);
      wr(2'd0, ctl(0, 2'b10, 1, 1));
      rd(2'd0, d); check("R1 ctrl readback", d, 8'h1C);
      set_count(16'hA55A);
      rd(2'd3, d); check("R1 high byte readback", d, 8'hA5);
      rd(2'd2, d); check("R1 low byte readback", d, 8'h5A);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_div(bit fast);
      logic [15:0] c0;
      int per;
      per = fast ? 4 : 12;
      set_count(16'h0100);
      wr(2'd0, ctl(1, fast ? 2'b01 : 2'b00, 0, 0));
      @(negedge clk); c0 = count_o;
      repeat (per * 10) @(negedge clk);
      check(fast ? "R3 div4 rate" : "R2 div12 rate", count_o - c0, 10);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_cascade;
      set_count(16'h0000);
      wr(2'd0, ctl(1, 2'b10, 0, 0));
      for (int i = 0; i < 5; i++) begin
         @(negedge clk) casc_ovf_i = 1'b1;
         @(negedge clk) casc_ovf_i = 1'b0;
         repeat (2) @(negedge clk);
      end
      check("R4 single pulses", count_o, 5);
      @(negedge clk) casc_ovf_i = 1'b1;
      repeat (3) @(negedge clk);
      casc_ovf_i = 1'b0;
      @(negedge clk);
      check("R4 held pulse", count_o, 8);
   endtask

   task automatic t_pin;
      set_count(16'h0010);
      wr(2'd0, ctl(1, 2'b11, 0, 0));
      @(negedge clk) ext_cnt_i = 1'b1;
      repeat (8) @(negedge clk);
      check("R5 first edge", count_o, 16'h0011);
      repeat (10) @(negedge clk);
      check("R5 held level", count_o, 16'h0011);
      ext_cnt_i = 1'b0;
      repeat (6) @(negedge clk);
      ext_cnt_i = 1'b1;
      repeat (8) @(negedge clk);
      check("R5 second edge", count_o, 16'h0012);
      ext_cnt_i = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_run_idle;
      logic [15:0] c0;
      set_count(16'h0200);
      wr(2'd0, ctl(0, 2'b01, 0, 0));
      repeat (40) @(negedge clk);
      check("R6 stopped", count_o, 16'h0200);
      idle_i = 1'b1;
      wr(2'd0, ctl(1, 2'b01, 1, 0));
      repeat (40) @(negedge clk);
      check("R7 idle halt", count_o, 16'h0200);
      wr(2'd0, ctl(1, 2'b01, 0, 0));
      @(negedge clk); c0 = count_o;
      repeat (40) @(negedge clk);
      check("R7 idle ignored", count_o - c0, 10);
      idle_i = 1'b0;
      wr(2'd0, 8'h00);
   endtask

   task automatic t_overflow;
      logic [7:0] d;
      set_count(16'hFFFE);
      wr(2'd0, ctl(1, 2'b10, 0, 0));
      for (int i = 0; i < 2; i++) begin
         @(negedge clk) casc_ovf_i = 1'b1;
         @(negedge clk) casc_ovf_i = 1'b0;
      end
      check("R8 wrap value", count_o, 0);
      repeat (5) @(negedge clk);
      rd(2'd1, d); check("R8 flag sticky", d, 1);
      check("R9 irq masked", irq_o, 0);
      wr(2'd0, ctl(1, 2'b10, 0, 1));
      check("R9 irq enabled", irq_o, 1);
      wr(2'd1, 8'h00);
      rd(2'd1, d); check("R8 flag cleared", d, 0);
      check("R9 irq dropped", irq_o, 0);
      wr(2'd1, 8'h01);
      rd(2'd1, d); check("R10 soft set", d, 1);
      check("R10 irq", irq_o, 1);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_collide;
      logic [7:0] d;
      set_count(16'h12FF);
      wr(2'd0, ctl(1, 2'b10, 0, 0));
      @(negedge clk);
      casc_ovf_i = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h55;
      @(negedge clk);
      casc_ovf_i = 1'b0; wr_en = 1'b0;
      check("R11 write beats increment", count_o, 16'h1255);
      set_count(16'hFFFF);
      @(negedge clk);
      casc_ovf_i = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00;
      @(negedge clk);
      casc_ovf_i = 1'b0; wr_en = 1'b0;
      check("R12 count wrapped", count_o, 0);
      rd(2'd1, d); check("R12 set beats clear", d, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_div(0);
      t_div(1);
      t_cascade;
      t_pin;
      t_run_idle;
      t_overflow;
      t_collide;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule